// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the low-power modes of a small microcontroller. Software picks a mode by writing an 8-bit mode-request register. Bit 0 requests the deep-sleep mode (HALT), in which every clocked subsystem and the oscillator are switched off. Bit 1 requests the light-sleep mode (IDLE), in which the oscillator, the watchdog and the periodic timer keep running and the rest is switched off. Both request bits are write-only and clear themselves when the mode they started ends. The block drives one enable per subsystem group and a stall line that holds the core for as long as it must not execute.

HALT ends only on a pulse from the external multi-input wakeup unit. The oscillator then needs time to settle, so the core stays stalled for a start-up interval of `STARTUP_CYCLES` reference-clock cycles. IDLE ends on the same wakeup pulse or when the internal wake interval of `IDLE_CYCLES` cycles runs out, and the core is released on the next cycle. Every wakeup sets a flag, and software clears it by writing zero to a separate clear register. The block runs on an always-on reference clock. The oscillator enable is only an output.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode` is 2'b00 (normal), all five enables are high, `core_stall` is low and `wake_flag` is low.
- R2: A write to the mode-request register in normal mode with bit 0 set enters HALT, and `mode` reads 2'b01 from the next cycle.
- R3: A write in normal mode with bit 1 set and bit 0 clear enters IDLE, and `mode` reads 2'b10 from the next cycle. Bits 7 to 2 are ignored, so a write with bits 1 and 0 both clear leaves the block in normal mode. Request writes made outside normal mode are ignored.
- R4: In HALT, `osc_en`, `wdt_en`, `tmr_en`, `sup_en` and `periph_en` are all low and `core_stall` is high.
- R5: In IDLE, `osc_en`, `wdt_en` and `tmr_en` are high, `sup_en` and `periph_en` are low, and `core_stall` is high.
- R6: HALT is left only when `wake_i` is high. It stays in HALT however long it lasts, including well past `IDLE_CYCLES` cycles.
- R7: A wakeup from HALT enters the start-up wait (`mode` 2'b11) for exactly `STARTUP_CYCLES` cycles. During the wait only `osc_en` is high and `core_stall` stays high. The block then returns to normal mode.
- R8: IDLE ends by itself after exactly `IDLE_CYCLES` cycles, counted from the first cycle in IDLE.
- R9: `wake_i` high during IDLE returns the block to normal mode on the next cycle, with `core_stall` low and no start-up wait.
- R10: A write with both bit 0 and bit 1 set enters HALT.
- R11: Any exit from HALT or IDLE sets `wake_flag`. A write of 8'h00 to the clear register clears it. A write of any other value to the clear register has no effect, and neither does `wake_i` in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Write strobe for the mode-request register |
| req_wdata | input | 8 | Mode-request data; bit 0 HALT, bit 1 IDLE |
| clr_wr | input | 1 | Write strobe for the wakeup-flag clear register |
| clr_wdata | input | 8 | Clear data; only 8'h00 clears |
| wake_i | input | 1 | Wakeup pulse from the multi-input wakeup unit |
| osc_en | output | 1 | Oscillator enable |
| wdt_en | output | 1 | Watchdog enable |
| tmr_en | output | 1 | Periodic timer enable |
| sup_en | output | 1 | Low-battery and brown-out supervisor enable |
| periph_en | output | 1 | Enable for all other subsystems |
| core_stall | output | 1 | Holds the core |
| wake_flag | output | 1 | Post-wakeup flag |
| mode | output | 2 | 00 normal, 01 HALT, 10 IDLE, 11 start-up wait |

## Verification
The IDLE timeout is the hardest case to reach. The bench has to enter IDLE and then hold `wake_i` low for the whole interval, and it must count exactly how many cycles `mode` stays at IDLE, so that an off-by-one in the interval counter shows up. The bench runs two full timeouts and counts cycles at each falling edge. It also holds HALT past the same interval to show that the timer cannot end HALT. Wakeups from IDLE are swept over several entry offsets, and the start-up wait is timed after HALT entries of different lengths.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_HALT   = 2'b01,
        PM_IDLE   = 2'b10,
        PM_START  = 2'b11
    } pm_state_e;

    typedef struct packed {
        logic osc;
        logic wdt;
        logic tmr;
        logic sup;
        logic periph;
    } pm_en_t;

    localparam int REQ_HALT_BIT = 0;
    localparam int REQ_IDLE_BIT = 1;

    function automatic pm_en_t enables_for(pm_state_e s);
        pm_en_t e;
        case (s)
            PM_NORMAL: e = '{osc: 1'b1, wdt: 1'b1, tmr: 1'b1, sup: 1'b1, periph: 1'b1};
            PM_IDLE:   e = '{osc: 1'b1, wdt: 1'b1, tmr: 1'b1, sup: 1'b0, periph: 1'b0};
            PM_START:  e = '{osc: 1'b1, wdt: 1'b0, tmr: 1'b0, sup: 1'b0, periph: 1'b0};
            default:   e = '{osc: 1'b0, wdt: 1'b0, tmr: 1'b0, sup: 1'b0, periph: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwr_interval_cnt.sv
module pwr_interval_cnt #(
    parameter int LIMIT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: a run that is not yet done moves the count up by exactly one
    a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
        (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_wr,
    input  logic      req_halt,
    input  logic      req_idle,
    input  logic      wake_i,
    input  logic      idle_done,
    input  logic      start_done,
    output pm_state_e state_q,
    output logic      exit_evt
);
    pm_state_e state_d;

    always_comb begin
        state_d  = state_q;
        exit_evt = 1'b0;
        case (state_q)
            PM_NORMAL: begin
                if (req_wr && req_halt) begin
                    state_d = PM_HALT;
                end else if (req_wr && req_idle) begin
                    state_d = PM_IDLE;
                end
            end
            PM_HALT: begin
                if (wake_i) begin
                    state_d  = PM_START;
                    exit_evt = 1'b1;
                end
            end
            PM_IDLE: begin
                if (wake_i || idle_done) begin
                    state_d  = PM_NORMAL;
                    exit_evt = 1'b1;
                end
            end
            default: begin
                if (start_done) begin
                    state_d = PM_NORMAL;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    a_r6_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_HALT && !wake_i) |=> (state_q == PM_HALT));

    a_r9_idle_wake_next: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_IDLE && wake_i) |=> (state_q == PM_NORMAL));

    a_r10_halt_priority: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_NORMAL && req_wr && req_halt) |=> (state_q == PM_HALT));

    a_r7_start_leaves_to_normal: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_START && start_done) |=> (state_q == PM_NORMAL));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int STARTUP_CYCLES = 32768,
    parameter int IDLE_CYCLES    = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_wr,
    input  logic [7:0] req_wdata,
    input  logic       clr_wr,
    input  logic [7:0] clr_wdata,
    input  logic       wake_i,
    output logic       osc_en,
    output logic       wdt_en,
    output logic       tmr_en,
    output logic       sup_en,
    output logic       periph_en,
    output logic       core_stall,
    output logic       wake_flag,
    output logic [1:0] mode
);
    pm_state_e state_q;
    pm_en_t    en;
    logic      exit_evt;
    logic      idle_done;
    logic      start_done;
    logic      flag_q;
    logic      unused_hi;

    assign unused_hi = ^req_wdata[7:2];

    pwr_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_wr     (req_wr),
        .req_halt   (req_wdata[REQ_HALT_BIT]),
        .req_idle   (req_wdata[REQ_IDLE_BIT]),
        .wake_i     (wake_i),
        .idle_done  (idle_done),
        .start_done (start_done),
        .state_q    (state_q),
        .exit_evt   (exit_evt)
    );

    pwr_interval_cnt #(.LIMIT(IDLE_CYCLES)) u_idle_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == PM_IDLE),
        .done (idle_done)
    );

    pwr_interval_cnt #(.LIMIT(STARTUP_CYCLES)) u_start_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == PM_START),
        .done (start_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (exit_evt) begin
            flag_q <= 1'b1;
        end else if (clr_wr && clr_wdata == 8'h00) begin
            flag_q <= 1'b0;
        end
    end

    assign en         = enables_for(state_q);
    assign osc_en     = en.osc;
    assign wdt_en     = en.wdt;
    assign tmr_en     = en.tmr;
    assign sup_en     = en.sup;
    assign periph_en  = en.periph;
    assign core_stall = (state_q != PM_NORMAL);
    assign wake_flag  = flag_q;
    assign mode       = state_q;

    a_r11_exit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        exit_evt |=> wake_flag);

    a_r8_timeout_to_normal: assert property (@(posedge clk) disable iff (rst)
        idle_done |=> (mode == 2'b00 && !core_stall));

    a_r4_halt_osc_off: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |-> (!osc_en && core_stall));

    a_r11_flag_only_rises_on_exit: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(exit_evt));

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    localparam int ST = 40;
    localparam int IC = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_wr = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic       clr_wr = 1'b0;
    logic [7:0] clr_wdata = 8'h00;
    logic       wake_i = 1'b0;
    logic       osc_en, wdt_en, tmr_en, sup_en, periph_en, core_stall, wake_flag;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_mode_seq #(.STARTUP_CYCLES(ST), .IDLE_CYCLES(IC)) u_pwr_mode_seq (
        .clk(clk), .rst(rst), .req_wr(req_wr), .req_wdata(req_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata), .wake_i(wake_i),
        .osc_en(osc_en), .wdt_en(wdt_en), .tmr_en(tmr_en), .sup_en(sup_en),
        .periph_en(periph_en), .core_stall(core_stall), .wake_flag(wake_flag),
        .mode(mode)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {osc_en, wdt_en, tmr_en, sup_en, periph_en, core_stall};
    endfunction

    task automatic write_req(logic [7:0] d);
        req_wr = 1'b1; req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0; req_wdata = 8'h00;
    endtask

    task automatic write_clr(logic [7:0] d);
        clr_wr = 1'b1; clr_wdata = d;
        @(negedge clk);
        clr_wr = 1'b0; clr_wdata = 8'h00;
    endtask

    task automatic pulse_wake();
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
    endtask

    task automatic count_mode(logic [1:0] m, output int n);
        n = 0;
        while (mode == m && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 outputs", outs(), 6'b111110);
        check("R1 flag", wake_flag, 0);

        // R3 undefined bits only: stay normal
        write_req(8'hFC);
        check("R3 upper bits ignored", mode, 0);
        pulse_wake();
        check("R11 wake in normal ignored", wake_flag, 0);

        // R2, R4, R6, R7 over several HALT lengths
        for (int h = 0; h < 4; h++) begin
            write_req(8'h01);
            check("R2 halt mode", mode, 1);
            check("R4 halt outputs", outs(), 6'b000001);
            write_req(8'h02);
            check("R3 write in halt ignored", mode, 1);
            repeat (h * 7) @(negedge clk);
            check("R6 still halt", mode, 1);
            pulse_wake();
            check("R7 start mode", mode, 3);
            check("R7 start outputs", outs(), 6'b100001);
            count_mode(2'b11, n);
            check("R7 start length", n, ST);
            check("R7 normal after start", outs(), 6'b111110);
            check("R11 flag after halt", wake_flag, 1);
            write_clr(8'h5A);
            check("R11 nonzero clear ignored", wake_flag, 1);
            write_clr(8'h00);
            check("R11 clear", wake_flag, 0);
        end

        // R6 HALT held past the idle interval
        write_req(8'h01);
        repeat (IC + 100) @(negedge clk);
        check("R6 halt past interval", mode, 1);
        pulse_wake();
        count_mode(2'b11, n);
        check("R7 start length long halt", n, ST);
        write_clr(8'h00);

        // R10 both bits
        write_req(8'h03);
        check("R10 halt priority", mode, 1);
        pulse_wake();
        count_mode(2'b11, n);
        write_clr(8'h00);

        // R8 IDLE timeout, twice
        for (int t = 0; t < 2; t++) begin
            write_req(8'hFE);
            check("R3 idle mode", mode, 2);
            check("R5 idle outputs", outs(), 6'b111001);
            count_mode(2'b10, n);
            check("R8 idle length", n, IC);
            check("R8 normal after timeout", outs(), 6'b111110);
            check("R11 flag after timeout", wake_flag, 1);
            write_clr(8'h00);
        end

        // R9 IDLE wake at several offsets
        for (int k = 0; k < 6; k++) begin
            write_req(8'h02);
            repeat (k * k * 5) @(negedge clk);
            check("R9 idle before wake", mode, 2);
            pulse_wake();
            check("R9 normal next cycle", mode, 0);
            check("R9 stall released", core_stall, 0);
            check("R11 flag after idle wake", wake_flag, 1);
            write_clr(8'h00);
            check("R11 cleared", wake_flag, 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule